// File: doc/BRIEF.md
# Atomic Read-Modify-Write Unit

This block owns a small word-addressed memory of 32-bit words and applies one atomic operation per request. A request carries a 4-bit operation code, a 4-bit type code, a 64-bit base, a signed offset, an operand and a compare value. The unit reads the old contents at the effective address, derives the new contents, and writes them back. Requests are handled strictly one at a time, so nothing can reach the word between the read and the write.

A request is either returning or non-returning. A returning request gets exactly one response that carries the old value. A non-returning request (a reduction) updates memory silently. Any request that is rejected completes with a single error response and leaves memory unchanged. Both request and response use valid/ready handshakes.

Top module: `atomic_rmw_unit`

## Requirements
- R1: After reset, reqReady is 1, rspValid is 0, and every memory word reads as zero.
- R2: The effective word address is the base plus the sign-extended offset. When reqWideAddr is 0, only the low 32 bits of the base are used. When it is 1, all 64 bits are used.
- R3: A request is rejected if its effective address is not below DEPTH, or if it is a 64-bit request at an odd address.
- R4: Operation codes are 0 ADD, 5 AND, 6 OR, 7 XOR and 8 EXCH (EXCH stores the operand). Arithmetic wraps modulo the operand width. A 32-bit request changes only the word at the effective address.
- R5: Operation codes 1 MIN and 2 MAX compare as signed for type 7 (signed 32-bit) and as unsigned for type 4 (unsigned 32-bit) and type 5 (unsigned 64-bit).
- R6: Code 3 INC stores 0 when old >= operand, and old+1 otherwise. Code 4 DEC stores the operand when old is 0 or old > operand, and old-1 otherwise. Both compare as unsigned.
- R7: Code 9 CAS writes the operand only when old equals the compare value (at the request width). It always returns the old value.
- R8: A type 5 request treats the word at the even effective address as the low half and the next word as the high half.
- R9: An operation code of 10 or more, or a type code other than 4, 5 or 7, is rejected. A rejected request gives one response with rspErr=1 and rspData=0, and does not write memory.
- R10: A non-returning request with code 8 (EXCH) or code 9 (CAS) is rejected as in R9.
- R11: Every returning request gets exactly one response, in request order, carrying the old value. A valid non-returning request gets none. While a response waits, rspValid, rspData and rspErr hold steady and reqReady stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request valid |
| reqReady | output | 1 | Unit can accept a request |
| reqOp | input | 4 | Operation code |
| reqType | input | 4 | Type code (4 u32, 5 u64, 7 s32) |
| reqReturn | input | 1 | 1 = returning atomic, 0 = reduction |
| reqWideAddr | input | 1 | Use all 64 base bits |
| reqBase | input | 64 | Base word address |
| reqOffset | input | OFF_W | Signed word offset |
| reqOperand | input | 64 | Operand |
| reqCompare | input | 64 | Compare value for CAS |
| rspValid | output | 1 | Response valid |
| rspReady | input | 1 | Response accepted |
| rspData | output | 64 | Old value, or 0 on error |
| rspErr | output | 1 | Request was rejected |

## Verification
The bench targets several corner cases, each of which exposes a specific wrong design:
- ADD carry between the two halves of a 64-bit value. A design that split the halves would leave the high word at zero.
- MIN and MAX on a word whose top bit is set. These give different answers for signed and unsigned types, so swapped signedness shows up at once.
- The wrap points of INC and DEC: old equal to the operand, and old equal to zero.
- CAS with an almost-matching compare value. A design that wrote unconditionally would change the word.
- Rejected requests, including reductions that ask for EXCH or CAS, each followed by a read-back. A design that wrote despite the error would show a changed word.
- Random response backpressure. A design that dropped, duplicated or reordered responses, or accepted a request while busy, would fail the scoreboard.

// File: rtl/atom_pkg.sv
package atom_pkg;

  localparam logic [3:0] OP_ADD  = 4'd0;
  localparam logic [3:0] OP_MIN  = 4'd1;
  localparam logic [3:0] OP_MAX  = 4'd2;
  localparam logic [3:0] OP_INC  = 4'd3;
  localparam logic [3:0] OP_DEC  = 4'd4;
  localparam logic [3:0] OP_AND  = 4'd5;
  localparam logic [3:0] OP_OR   = 4'd6;
  localparam logic [3:0] OP_XOR  = 4'd7;
  localparam logic [3:0] OP_EXCH = 4'd8;
  localparam logic [3:0] OP_CAS  = 4'd9;

  localparam logic [3:0] TY_U32 = 4'd4;
  localparam logic [3:0] TY_U64 = 4'd5;
  localparam logic [3:0] TY_S32 = 4'd7;

  typedef struct packed {
    logic latchReq;
    logic exec;
    logic captureRsp;
  } atom_strobe_t;

endpackage

// File: rtl/atom_alu.sv
module atom_alu
  import atom_pkg::*;
(
  input  logic [3:0]  op,
  input  logic        is64,
  input  logic        isSigned,
  input  logic [63:0] oldVal,
  input  logic [63:0] operand,
  input  logic [63:0] compare,
  output logic [63:0] newVal,
  output logic        doWrite
);

  logic [63:0] mask, a, b, c, res;
  logic lessU, lessS, less;

  always_comb begin
    mask  = is64 ? 64'hFFFF_FFFF_FFFF_FFFF : 64'h0000_0000_FFFF_FFFF;
    a     = oldVal & mask;
    b     = operand & mask;
    c     = compare & mask;
    lessU = a < b;
    lessS = $signed(a[31:0]) < $signed(b[31:0]);
    less  = (isSigned && !is64) ? lessS : lessU;
    doWrite = 1'b1;
    unique case (op)
      OP_ADD:  res = a + b;
      OP_MIN:  res = less ? a : b;
      OP_MAX:  res = less ? b : a;
      OP_INC:  res = (a >= b) ? 64'd0 : a + 64'd1;
      OP_DEC:  res = ((a == 64'd0) || (a > b)) ? b : a - 64'd1;
      OP_AND:  res = a & b;
      OP_OR:   res = a | b;
      OP_XOR:  res = a ^ b;
      OP_EXCH: res = b;
      OP_CAS: begin
        res     = b;
        doWrite = (a == c);
      end
      default: begin
        res     = a;
        doWrite = 1'b0;
      end
    endcase
    newVal = res & mask;
  end

endmodule

// File: rtl/atom_ctrl.sv
module atom_ctrl
  import atom_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         reqValid,
  output logic         reqReady,
  output logic         rspValid,
  input  logic         rspReady,
  input  logic         needRsp,
  output atom_strobe_t strobe
);

  typedef enum logic [1:0] { S_IDLE, S_EXEC, S_RESP } state_t;
  state_t state, stateNext;

  always_comb begin
    stateNext = state;
    strobe    = '0;
    reqReady  = 1'b0;
    rspValid  = 1'b0;
    unique case (state)
      S_IDLE: begin
        reqReady = 1'b1;
        if (reqValid) begin
          strobe.latchReq = 1'b1;
          stateNext       = S_EXEC;
        end
      end
      S_EXEC: begin
        strobe.exec = 1'b1;
        if (needRsp) begin
          strobe.captureRsp = 1'b1;
          stateNext         = S_RESP;
        end else begin
          stateNext = S_IDLE;
        end
      end
      S_RESP: begin
        rspValid = 1'b1;
        if (rspReady) stateNext = S_IDLE;
      end
      default: stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= stateNext;
  end

  // R11: a pending response is not withdrawn
  a_r11_rsp_held: assert property (@(posedge clk) disable iff (!rstN)
    rspValid && !rspReady |=> rspValid);

  // R11: no acceptance while a response waits
  a_r11_busy_no_accept: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> !reqReady);

endmodule

// File: rtl/atom_datapath.sv
module atom_datapath
  import atom_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int OFF_W = 20
) (
  input  logic               clk,
  input  logic               rstN,
  input  atom_strobe_t       strobe,
  input  logic [3:0]         reqOp,
  input  logic [3:0]         reqType,
  input  logic               reqReturn,
  input  logic               reqWideAddr,
  input  logic [63:0]        reqBase,
  input  logic [OFF_W-1:0]   reqOffset,
  input  logic [63:0]        reqOperand,
  input  logic [63:0]        reqCompare,
  output logic               needRsp,
  output logic [63:0]        rspData,
  output logic               rspErr
);

  localparam int          IDX_W   = $clog2(DEPTH);
  localparam logic [63:0] DEPTH_L = 64'(DEPTH);

  logic [DEPTH-1:0][31:0] mem;

  logic [3:0]  opR, typeR;
  logic        retR;
  logic [63:0] eaR, opdR, cmpR;

  logic [63:0] baseEff, offExt;
  always_comb begin
    baseEff = reqWideAddr ? reqBase : {32'd0, reqBase[31:0]};
    offExt  = {{(64-OFF_W){reqOffset[OFF_W-1]}}, reqOffset};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      opR   <= '0;
      typeR <= TY_U32;
      retR  <= 1'b0;
      eaR   <= '0;
      opdR  <= '0;
      cmpR  <= '0;
    end else if (strobe.latchReq) begin
      opR   <= reqOp;
      typeR <= reqType;
      retR  <= reqReturn;
      eaR   <= baseEff + offExt;
      opdR  <= reqOperand;
      cmpR  <= reqCompare;
    end
  end

  logic is64, isSigned, typeOk, opOk, kindOk, rangeOk, alignOk, reqErr;
  logic [IDX_W-1:0] idxLo, idxHi;
  logic [63:0] oldVal, newVal;
  logic doWrite;

  always_comb begin
    is64     = (typeR == TY_U64);
    isSigned = (typeR == TY_S32);
    typeOk   = (typeR == TY_U32) || (typeR == TY_U64) || (typeR == TY_S32);
    opOk     = (opR <= OP_CAS);
    kindOk   = retR || (opR < OP_EXCH);
    rangeOk  = (eaR < DEPTH_L);
    alignOk  = !is64 || !eaR[0];
    reqErr   = !(typeOk && opOk && kindOk && rangeOk && alignOk);
    needRsp  = retR || reqErr;
    idxLo    = eaR[IDX_W-1:0];
    idxHi    = idxLo | IDX_W'(1);
    oldVal   = is64 ? {mem[idxHi], mem[idxLo]} : {32'd0, mem[idxLo]};
  end

  atom_alu u_alu (
    .op       (opR),
    .is64     (is64),
    .isSigned (isSigned),
    .oldVal   (oldVal),
    .operand  (opdR),
    .compare  (cmpR),
    .newVal   (newVal),
    .doWrite  (doWrite)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      mem <= '0;
    end else if (strobe.exec && !reqErr && doWrite) begin
      mem[idxLo] <= newVal[31:0];
      if (is64) mem[idxHi] <= newVal[63:32];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspData <= '0;
      rspErr  <= 1'b0;
    end else if (strobe.captureRsp) begin
      rspData <= reqErr ? 64'd0 : oldVal;
      rspErr  <= reqErr;
    end
  end

  // R9: a rejected request leaves memory untouched
  a_r9_err_mem_stable: assert property (@(posedge clk) disable iff (!rstN)
    strobe.exec && reqErr |=> $stable(mem));

  // R7: a compare miss leaves memory untouched
  a_r7_cas_miss_stable: assert property (@(posedge clk) disable iff (!rstN)
    strobe.exec && !reqErr && opR == OP_CAS &&
    (is64 ? (oldVal != cmpR) : (oldVal[31:0] != cmpR[31:0])) |=> $stable(mem));

  // R10: a reduction asking for EXCH or CAS writes nothing and answers
  a_r10_reduction_swap_rejected: assert property (@(posedge clk) disable iff (!rstN)
    strobe.exec && !retR && (opR == OP_EXCH || opR == OP_CAS) |-> strobe.captureRsp);

endmodule

// File: rtl/atomic_rmw_unit.sv
module atomic_rmw_unit
  import atom_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int OFF_W = 20
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  output logic             reqReady,
  input  logic [3:0]       reqOp,
  input  logic [3:0]       reqType,
  input  logic             reqReturn,
  input  logic             reqWideAddr,
  input  logic [63:0]      reqBase,
  input  logic [OFF_W-1:0] reqOffset,
  input  logic [63:0]      reqOperand,
  input  logic [63:0]      reqCompare,
  output logic             rspValid,
  input  logic             rspReady,
  output logic [63:0]      rspData,
  output logic             rspErr
);

  atom_strobe_t strobe;
  logic needRsp;

  atom_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqReady (reqReady),
    .rspValid (rspValid),
    .rspReady (rspReady),
    .needRsp  (needRsp),
    .strobe   (strobe)
  );

  atom_datapath #(.DEPTH(DEPTH), .OFF_W(OFF_W)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .reqOp       (reqOp),
    .reqType     (reqType),
    .reqReturn   (reqReturn),
    .reqWideAddr (reqWideAddr),
    .reqBase     (reqBase),
    .reqOffset   (reqOffset),
    .reqOperand  (reqOperand),
    .reqCompare  (reqCompare),
    .needRsp     (needRsp),
    .rspData     (rspData),
    .rspErr      (rspErr)
  );

  // R11: response payload holds under backpressure
  a_r11_payload_hold: assert property (@(posedge clk) disable iff (!rstN)
    rspValid && !rspReady |=> $stable(rspData) && $stable(rspErr));

endmodule

// File: tb/sim_atomic_rmw_unit.sv
`timescale 1ns/1ps
module sim_atomic_rmw_unit;

  localparam int DEPTH = 16;
  localparam int OFF_W = 20;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic reqReady;
  logic [3:0] reqOp = '0, reqType = 4'd4;
  logic reqReturn = 1'b0, reqWideAddr = 1'b0;
  logic [63:0] reqBase = '0, reqOperand = '0, reqCompare = '0;
  logic [OFF_W-1:0] reqOffset = '0;
  logic rspValid;
  logic rspReady = 1'b1;
  logic [63:0] rspData;
  logic rspErr;

  always #2.5 clk = ~clk;

  atomic_rmw_unit #(.DEPTH(DEPTH), .OFF_W(OFF_W)) u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqOp(reqOp), .reqType(reqType), .reqReturn(reqReturn),
    .reqWideAddr(reqWideAddr), .reqBase(reqBase), .reqOffset(reqOffset),
    .reqOperand(reqOperand), .reqCompare(reqCompare),
    .rspValid(rspValid), .rspReady(rspReady), .rspData(rspData), .rspErr(rspErr)
  );

  typedef struct {
    logic [63:0] data;
    logic        err;
    string       tag;
  } exp_t;

  exp_t expQ[$];
  logic [31:0] model [DEPTH];
  int checks = 0;
  int fails = 0;
  bit finished = 0;
  bit bpMode = 0;
  logic [7:0] lfsr = 8'hA5;

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] refNew(input logic [3:0] op, input logic is64,
      input logic sgn, input logic [63:0] oldV, input logic [63:0] opd,
      input logic [63:0] cmp, output logic wr);
    logic [63:0] m, a, b, c, r;
    logic lt;
    m = is64 ? '1 : 64'hFFFF_FFFF;
    a = oldV & m; b = opd & m; c = cmp & m;
    lt = (sgn && !is64) ? ($signed(a[31:0]) < $signed(b[31:0])) : (a < b);
    wr = 1'b1;
    case (op)
      4'd0: r = a + b;
      4'd1: r = lt ? a : b;
      4'd2: r = lt ? b : a;
      4'd3: r = (a >= b) ? 0 : a + 1;
      4'd4: r = (a == 0 || a > b) ? b : a - 1;
      4'd5: r = a & b;
      4'd6: r = a | b;
      4'd7: r = a ^ b;
      4'd8: r = b;
      default: begin r = b; wr = (a == c); end
    endcase
    return r & m;
  endfunction

  task automatic issue(input string tag, input logic [3:0] op, input logic [3:0] ty,
      input logic ret, input logic wide, input logic [63:0] base,
      input logic [19:0] off, input logic [63:0] opd, input logic [63:0] cmp);
    logic [63:0] ea, oldV, nv;
    logic is64, err, wr;
    exp_t e;
    ea = (wide ? base : {32'd0, base[31:0]}) + {{44{off[19]}}, off};
    is64 = (ty == 4'd5);
    err = (op > 4'd9) || !(ty == 4'd4 || ty == 4'd5 || ty == 4'd7) ||
          (!ret && op >= 4'd8) || (ea >= 64'(DEPTH)) || (is64 && ea[0]);
    oldV = 0;
    if (!err) begin
      oldV = is64 ? {model[ea[3:0] | 4'd1], model[ea[3:0]]} : {32'd0, model[ea[3:0]]};
      nv = refNew(op, is64, ty == 4'd7, oldV, opd, cmp, wr);
      if (wr) begin
        model[ea[3:0]] = nv[31:0];
        if (is64) model[ea[3:0] | 4'd1] = nv[63:32];
      end
    end
    if (err || ret) begin
      e.data = err ? 64'd0 : oldV;
      e.err = err;
      e.tag = tag;
      expQ.push_back(e);
    end
    while (!reqReady) @(negedge clk);
    reqOp = op; reqType = ty; reqReturn = ret; reqWideAddr = wide;
    reqBase = base; reqOffset = off; reqOperand = opd; reqCompare = cmp;
    reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic rd(input string tag, input int idx);
    issue(tag, 4'd6, 4'd4, 1'b1, 1'b0, 64'(idx), 20'd0, 64'd0, 64'd0);
  endtask

  task automatic wr32(input string tag, input int idx, input logic [31:0] v);
    issue(tag, 4'd8, 4'd4, 1'b1, 1'b0, 64'(idx), 20'd0, {32'd0, v}, 64'd0);
  endtask

  // response backpressure driver
  always @(posedge clk) begin
    #1;
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    rspReady = bpMode ? lfsr[0] : 1'b1;
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (rstN && !finished) begin
      if (rspValid && !rspReady) check("R11 busy reqReady", 64'(reqReady), 64'd0);
      if (rspValid && rspReady) begin
        if (expQ.size() == 0) begin
          checks++; fails++;
          $display("FAIL R11 unexpected response actual=%h expected=none", rspData);
        end else begin
          exp_t e;
          e = expQ.pop_front();
          check({e.tag, " data"}, rspData, e.data);
          check({e.tag, " err"}, 64'(rspErr), 64'(e.err));
        end
      end
    end
  end

  // watchdog
  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !finished) begin
      finished = 1;
      fails++; checks++;
      $display("FAIL watchdog actual=%0d expected<100000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) model[i] = 32'd0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 reqReady", 64'(reqReady), 64'd1);
    check("R1 rspValid", 64'(rspValid), 64'd0);
    for (int i = 0; i < DEPTH; i++) rd("R1", i);

    // R4 basic ops and wrap
    issue("R4 add", 4'd0, 4'd4, 1, 0, 64'd3, 20'd0, 64'd10, 0);
    issue("R4 add", 4'd0, 4'd4, 1, 0, 64'd3, 20'd0, 64'd5, 0);
    wr32("R4 exch", 3, 32'hFFFF_FFFF);
    issue("R4 wrap", 4'd0, 4'd4, 1, 0, 64'd3, 20'd0, 64'd2, 0);
    rd("R4", 3);
    wr32("R4", 4, 32'h0000_F0F0);
    issue("R4 and", 4'd5, 4'd4, 1, 0, 64'd4, 20'd0, 64'hFF00, 0);
    issue("R4 or", 4'd6, 4'd4, 1, 0, 64'd4, 20'd0, 64'h000F, 0);
    issue("R4 xor", 4'd7, 4'd4, 1, 0, 64'd4, 20'd0, 64'hFFFF, 0);
    rd("R4", 4);
    rd("R4 neighbour", 5);

    // R2 address formation, R3 rejects
    issue("R2 narrow", 4'd6, 4'd4, 1, 0, 64'hABCD_0000_0000_0005, 20'hFFFFE, 0, 0);
    issue("R3 wide", 4'd6, 4'd4, 1, 1, 64'hABCD_0000_0000_0005, 20'hFFFFE, 0, 0);
    issue("R2 pos", 4'd6, 4'd4, 1, 0, 64'd1, 20'd6, 0, 0);
    issue("R3 range", 4'd0, 4'd4, 1, 0, 64'd16, 20'd0, 64'd1, 0);
    issue("R3 neg", 4'd0, 4'd4, 1, 0, 64'd0, 20'hFFFFF, 64'd1, 0);
    issue("R3 odd64", 4'd0, 4'd5, 1, 0, 64'd5, 20'd0, 64'd1, 0);
    rd("R3", 5);

    // R5 signedness
    wr32("R5", 5, 32'hFFFF_FFF0);
    issue("R5 smin", 4'd1, 4'd7, 1, 0, 64'd5, 20'd0, 64'd3, 0);
    rd("R5", 5);
    issue("R5 umin", 4'd1, 4'd4, 1, 0, 64'd5, 20'd0, 64'd3, 0);
    issue("R5 smax", 4'd2, 4'd7, 1, 0, 64'd5, 20'd0, 64'hFFFF_FFFE, 0);
    issue("R5 umax", 4'd2, 4'd4, 1, 0, 64'd5, 20'd0, 64'hFFFF_FFFE, 0);
    rd("R5", 5);

    // R6 INC/DEC wrap points
    wr32("R6", 6, 32'd5);
    issue("R6 inc", 4'd3, 4'd4, 1, 0, 64'd6, 20'd0, 64'd5, 0);
    issue("R6 inc", 4'd3, 4'd4, 1, 0, 64'd6, 20'd0, 64'd5, 0);
    issue("R6 dec", 4'd4, 4'd4, 1, 0, 64'd6, 20'd0, 64'd7, 0);
    issue("R6 dec", 4'd4, 4'd4, 1, 0, 64'd6, 20'd0, 64'd7, 0);
    wr32("R6", 6, 32'd9);
    issue("R6 dec", 4'd4, 4'd4, 1, 0, 64'd6, 20'd0, 64'd7, 0);
    rd("R6", 6);

    // R7 CAS
    wr32("R7", 7, 32'h55);
    issue("R7 miss", 4'd9, 4'd4, 1, 0, 64'd7, 20'd0, 64'h99, 64'h54);
    rd("R7", 7);
    issue("R7 hit", 4'd9, 4'd4, 1, 0, 64'd7, 20'd0, 64'h99, 64'h55);
    rd("R7", 7);

    // R8 64-bit pair
    wr32("R8", 8, 32'hFFFF_FFFF);
    wr32("R8", 9, 32'd0);
    issue("R8 add64", 4'd0, 4'd5, 1, 0, 64'd8, 20'd0, 64'd1, 0);
    issue("R8 rd64", 4'd6, 4'd5, 1, 0, 64'd8, 20'd0, 0, 0);
    rd("R8 hi", 9);
    rd("R8 lo", 8);
    issue("R8 max64", 4'd2, 4'd5, 1, 0, 64'd8, 20'd0, 64'h1_0000_0001, 0);
    issue("R8 cas64", 4'd9, 4'd5, 1, 0, 64'd8, 20'd0, 64'h7, 64'h1_0000_0001);
    issue("R8 rd64", 4'd6, 4'd5, 1, 0, 64'd8, 20'd0, 0, 0);

    // R9 invalid codes
    issue("R9 op10", 4'd10, 4'd4, 1, 0, 64'd8, 20'd0, 64'd1, 0);
    issue("R9 op15", 4'd15, 4'd4, 0, 0, 64'd8, 20'd0, 64'd1, 0);
    issue("R9 ty6", 4'd0, 4'd6, 1, 0, 64'd8, 20'd0, 64'd1, 0);
    issue("R9 ty0", 4'd0, 4'd0, 0, 0, 64'd8, 20'd0, 64'd1, 0);
    rd("R9", 8);

    // R10 reductions with EXCH/CAS
    issue("R10 exch", 4'd8, 4'd4, 0, 0, 64'd7, 20'd0, 64'd1, 0);
    issue("R10 cas", 4'd9, 4'd4, 0, 0, 64'd7, 20'd0, 64'd1, 64'h99);
    rd("R10", 7);

    // R11 silent reduction, then backpressure run
    issue("R11 red", 4'd0, 4'd4, 0, 0, 64'd7, 20'd0, 64'd1, 0);
    rd("R11", 7);
    bpMode = 1;
    for (int i = 0; i < 24; i++) begin
      issue("R11 bp", 4'd0, 4'd4, (i % 3) != 0, 0, 64'd10, 20'd0, 64'(i + 1), 0);
    end
    rd("R11", 10);
    for (int i = 0; i < 2000 && (expQ.size() != 0 || rspValid); i++) @(negedge clk);
    bpMode = 0;
    repeat (4) @(negedge clk);
    check("R11 drained", 64'(expQ.size()), 64'd0);
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule